// File: doc/BRIEF.md
# Keyed Watchdog Timer with Shared-Length Alarm Pulses

This block is a watchdog timer that sits on a simple APB-style register bus. A 32-bit down-counter starts from a programmable reload value. Once the counter is armed, it counts down by one for every tick. If software does not refresh it in time, it reaches zero. At that moment it raises a sticky status flag. It also fires up to three alarm outputs (a reset request, an interrupt and an external signal), each gated by its own enable bit. All three outputs share one programmable pulse length, counted in bus clock cycles.

Software refreshes the timer only by writing a 16-bit key to the restart register. Any other value written there is dropped. The tick comes either from the bus clock or from the rising edges of a slower external clock. That clock is brought into the bus clock domain through a two-flop synchronizer followed by an edge detector. For this to work, the external clock period must be more than twice the bus clock period.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the reload register and the counter both hold 0x03EF1480, the pulse-length register holds 0xFF, and the control and status registers hold 0. All three alarm outputs are low.
- R2: Registers are selected by paddr[4:2]:
  - 0x00: counter (read only)
  - 0x04: reload value
  - 0x08: restart key
  - 0x0C: control
  - 0x10: status
  - 0x14: status clear
  - 0x18: pulse length

  The restart and clear registers read as zero. Unused bits read as zero. Offsets from 0x1C upward read as zero.
- R3: A write to 0x08 whose low 16 bits equal 0x5AB9 copies the reload value into the counter. A write to 0x08 with any other value leaves the counter unchanged.
- R4: A write to control that sets bit 0 while bit 0 is currently 0 loads the counter from the reload register. Writing bit 0 as 1 while it is already 1 does not reload the counter.
- R5: The counter decrements by exactly one per tick, and only while control bit 0 is 1. With bit 0 at 0, the counter holds its value.
- R6: When the counter steps from 1 to 0, status bit 0 becomes 1 and the counter holds at zero until it is reloaded. Writing 1 to bit 0 of the clear register clears the flag. Writing 0 there leaves the flag unchanged.
- R7: When the counter steps from 1 to 0, each alarm output whose enable bit is set goes high for exactly L bus cycles, starting in the cycle after the step, where L is the pulse-length value. The enable bits are control bit 1 for the reset request, bit 2 for the interrupt and bit 3 for the external signal. The outputs pulse once per expiry and stay low while the counter rests at zero.
- R8: Control bit 4 selects the tick source. With bit 4 at 0, the counter ticks on every bus clock cycle. With bit 4 at 1, it ticks once per rising edge of the external clock, after that edge passes a two-flop synchronizer. Steady high or low levels on the external clock produce no ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Register select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 5 | Byte address of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data for paddr |
| ext_clk | input | 1 | Optional slow external tick clock |
| rst_req | output | 1 | Reset request pulse |
| irq | output | 1 | Interrupt pulse |
| ext_sig | output | 1 | External alarm pulse |

## Verification
The bench keeps the default parameter values, including the 32-bit counter and the 8-bit pulse length. It programs small reload values (1 to 7) and pulse lengths (1 to 4) through the registers. This makes every expiry reachable within a few dozen cycles, so the sweep can compare the counter and the three outputs in every cycle of each run. The output-enable mask is rotated across the sweep so each alarm output is seen both gated on and gated off. Separate runs cover the key mismatch, the freeze while disabled, and the external-clock tick with its synchronizer delay.

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int          CNT_W      = 32,
  parameter int          LEN_W      = 8,
  parameter logic [31:0] RELOAD_RST = 32'h03EF1480,
  parameter logic [7:0]  LEN_RST    = 8'hFF,
  parameter logic [15:0] KEY        = 16'h5AB9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [4:0]  paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  input  logic        ext_clk,
  output logic        rst_req,
  output logic        irq,
  output logic        ext_sig
);
  localparam int CTRL_W = 5;

  logic [CNT_W-1:0]  cnt, reload;
  logic [LEN_W-1:0]  plen, pcnt;
  logic [CTRL_W-1:0] ctrl;
  logic              status;
  logic [2:0]        ext_s;

  wire [2:0] idx   = paddr[4:2];
  wire       wr    = psel && penable && pwrite;
  wire       wr_ld = wr && idx == 3'd1;
  wire       wr_rs = wr && idx == 3'd2;
  wire       wr_ct = wr && idx == 3'd3;
  wire       wr_cl = wr && idx == 3'd5;
  wire       wr_ln = wr && idx == 3'd6;

  wire key_ok   = wr_rs && pwdata[15:0] == KEY;
  wire arm      = wr_ct && pwdata[0] && !ctrl[0];
  wire load     = key_ok || arm;
  wire ext_rise = ext_s[1] && !ext_s[2];
  wire tick     = ctrl[4] ? ext_rise : 1'b1;
  wire dec      = ctrl[0] && tick && cnt != '0;
  wire expire   = !load && dec && cnt == CNT_W'(1);
  wire busy     = pcnt != '0;

  assign rst_req = busy && ctrl[1];
  assign irq     = busy && ctrl[2];
  assign ext_sig = busy && ctrl[3];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ext_s <= '0;
    else        ext_s <= {ext_s[1:0], ext_clk};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      reload <= RELOAD_RST[CNT_W-1:0];
      plen   <= LEN_RST[LEN_W-1:0];
      ctrl   <= '0;
    end else begin
      if (wr_ld) reload <= pwdata[CNT_W-1:0];
      if (wr_ln) plen   <= pwdata[LEN_W-1:0];
      if (wr_ct) ctrl   <= pwdata[CTRL_W-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    cnt <= RELOAD_RST[CNT_W-1:0];
    else if (load) cnt <= reload;
    else if (dec)  cnt <= cnt - CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 status <= 1'b0;
    else if (expire)            status <= 1'b1;
    else if (wr_cl && pwdata[0]) status <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      pcnt <= '0;
    else if (expire) pcnt <= plen;
    else if (busy)   pcnt <= pcnt - LEN_W'(1);

  always_comb begin
    prdata = '0;
    case (idx)
      3'd0: prdata = 32'(cnt);
      3'd1: prdata = 32'(reload);
      3'd3: prdata = 32'(ctrl);
      3'd4: prdata = {31'b0, status};
      3'd6: prdata = 32'(plen);
      default: prdata = '0;
    endcase
  end

  a_r5_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !load) |=> $stable(cnt));
  a_r6_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !load) |=> cnt == '0);
  a_r6_status_set: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> status);
  a_r7_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(expire));
  a_r8_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> !ext_rise);
endmodule

// File: tb/tb_keyed_watchdog.sv
module tb_keyed_watchdog;
  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0, ext_clk = 0;
  logic [4:0] paddr = 0;
  logic [31:0] pwdata = 0, prdata;
  logic rst_req, irq, ext_sig;
  int checks = 0, errors = 0;

  keyed_watchdog dut (.clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .ext_clk(ext_clk), .rst_req(rst_req), .irq(irq), .ext_sig(ext_sig));

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0; paddr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk); paddr = a; psel = 1; #1 v = prdata; psel = 0; paddr = 0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, v1;
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(5'h04, v); check("R1 reload", v, 32'h03EF1480);
    rd(5'h00, v); check("R1 counter", v, 32'h03EF1480);
    rd(5'h18, v); check("R1 len", v, 32'hFF);
    rd(5'h0C, v); check("R1 ctrl", v, 0);
    rd(5'h10, v); check("R1 status", v, 0);
    check("R1 outputs", {rst_req, irq, ext_sig}, 0);
    // R2 decode
    rd(5'h1C, v); check("R2 unmapped", v, 0);
    wr(5'h0C, 32'hFFFF_FFE0); rd(5'h0C, v); check("R2 ctrl unused bits", v, 0);
    wr(5'h08, 32'h5AB9); rd(5'h08, v); check("R2 restart reads zero", v, 0);
    wr(5'h04, 32'hFFFF_FFFF); rd(5'h04, v); check("R2 reload rw", v, 32'hFFFF_FFFF);

    // R4 R5 R6 R7 sweep
    for (int r = 1; r <= 7; r++)
      for (int l = 1; l <= 4; l++) begin
        logic [2:0] m;
        m = 3'(((r + l) % 7) + 1);
        wr(5'h0C, 0); wr(5'h14, 1);
        wr(5'h04, r); wr(5'h18, l);
        wr(5'h0C, {27'b0, 1'b0, m, 1'b1});
        #1 check("R4 arm load", prdata, r);
        for (int k = 1; k <= r + l + 3; k++) begin
          logic a;
          @(negedge clk); #1;
          check("R5 countdown", prdata, (k < r) ? r - k : 0);
          a = (k >= r) && (k < r + l);
          check("R7 pulses", {ext_sig, irq, rst_req}, {m[2] & a, m[1] & a, m[0] & a});
        end
        rd(5'h10, v); check("R6 status set", v, 1);
      end

    // R6 clear
    wr(5'h14, 0); rd(5'h10, v); check("R6 clear zero ignored", v, 1);
    wr(5'h14, 1); rd(5'h10, v); check("R6 clear", v, 0);

    // R3 key, R4 no re-arm, R7 once per expiry
    wr(5'h0C, 32'h0F); rd(5'h00, v); check("R4 no reload when enabled", v, 0);
    wr(5'h04, 50);
    wr(5'h08, 32'h1234); rd(5'h00, v); check("R3 bad key", v, 0);
    wr(5'h08, 32'h5AB8); rd(5'h00, v); check("R3 near key", v, 0);
    wr(5'h08, 32'h5AB9); #1 check("R3 key restart", prdata, 50);
    hi = 0;
    for (int k = 0; k < 90; k++) begin @(negedge clk); hi += int'(rst_req); end
    check("R7 once per expiry", hi, 4);
    rd(5'h00, v); check("R6 hold zero", v, 0);

    // R5 freeze
    wr(5'h04, 20); wr(5'h08, 32'h5AB9);
    wr(5'h0C, 32'h0E);
    rd(5'h00, v1); check("R5 freeze value", v1, 17);
    repeat (10) @(negedge clk);
    rd(5'h00, v); check("R5 frozen", v, 17);

    // R8 external tick
    wr(5'h04, 100); wr(5'h18, 2); wr(5'h0C, 32'h11);
    repeat (10) @(negedge clk);
    rd(5'h00, v); check("R8 no bus tick", v, 100);
    for (int n = 1; n <= 6; n++) begin
      @(negedge clk); ext_clk = 1;
      repeat (6) @(negedge clk); ext_clk = 0;
      repeat (6) @(negedge clk);
      #1 check("R8 ext tick", prdata, 100 - n);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule